// File: doc/BRIEF.md
# Synthetic Traffic Destination Generator

This block picks the destination router for one packet of synthetic network traffic on a two-dimensional mesh of routers. The mesh is `MESH_X` columns by `MESH_Y` rows, 5 by 5 by default. A traffic source presents its own X/Y position, a pattern code and a request. One cycle later the block returns the destination X/Y, marked by a valid strobe.

Six of the patterns are fixed permutations: for a given source they always produce the same target. The other two behave differently. Uniform random draws a node from a supplied random value and never returns the source itself. Hotspot sends every request to one configured node until a configured quota of hotspot packets has been issued. After that it falls back to a configured background pattern. A start pulse re-arms the hotspot quota.

The bit-level patterns treat the source position as one word, `{Y,X}`, with Y in the upper bits. Each coordinate field is `clog2` of its mesh dimension wide. Any coordinate that comes out beyond the mesh edge is clamped to that edge.

Top module: `synth_dest_gen`

## Requirements
- R1: While reset is asserted and right after it, `valid_o` is 0 and both destination outputs are 0. The hotspot counter is also cleared.
- R2: `valid_o` is 1 in exactly the cycle after a cycle with `req_i` high, and 0 after a cycle without it.
- R3: Pattern code 1 (complement) gives the destination X = `MESH_X`-1 minus the source X, and the destination Y = `MESH_Y`-1 minus the source Y.
- R4: Pattern code 2 (reversal) reverses all bits of `{Y,X}`. The low X-width bits of the result become X and the rest become Y. A coordinate above the mesh maximum is clamped to that maximum.
- R5: Pattern code 3 (transpose) gives destination X = source Y and destination Y = source X, clamped as in R4.
- R6: Pattern code 4 (shuffle) rotates `{Y,X}` left by one bit, then splits and clamps as in R4.
- R7: Pattern code 5 (rotation) rotates `{Y,X}` right by one bit, then splits and clamps as in R4.
- R8: Pattern code 0 (uniform) takes node index k = `rand_i` mod (`MESH_X`·`MESH_Y`). If k equals the source index (Y·`MESH_X`+X), it uses (k+1) mod the node count instead. The destination is X = k mod `MESH_X`, Y = k div `MESH_X`, so it never equals the source.
- R9: With pattern code 6 (hotspot), while the count of hotspot-mode requests already issued is below `hot_quota_i`, the destination is the hotspot node (`hot_x_i`, `hot_y_i`, each clamped to the mesh). Each such request adds one to the count.
- R10: With pattern code 6, once the count has reached `hot_quota_i`, the destination follows `bg_pattern_i` as codes 0 to 5 would, and the count stays put. Background codes 6 and 7 act as complement.
- R11: `start_i` clears the hotspot count. A request in the same cycle as `start_i` sees a count of zero.
- R12: Pattern code 7 acts as complement. In a cycle without a request, the destination outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the hotspot packet count |
| req_i | input | 1 | Request a destination for the presented source |
| pattern_i | input | 3 | Traffic pattern code (0 uniform, 1 complement, 2 reversal, 3 transpose, 4 shuffle, 5 rotation, 6 hotspot, 7 as 1) |
| bg_pattern_i | input | 3 | Pattern used by hotspot mode after its quota is met |
| src_x_i | input | XW | Source column |
| src_y_i | input | YW | Source row |
| hot_x_i | input | XW | Hotspot node column |
| hot_y_i | input | YW | Hotspot node row |
| hot_quota_i | input | CW | Number of hotspot packets before background traffic |
| rand_i | input | RW | Random value for uniform mode |
| dst_x_o | output | XW | Destination column |
| dst_y_o | output | YW | Destination row |
| valid_o | output | 1 | Destination outputs carry the answer to the previous cycle's request |

## Verification
Every result comes out of a single output register. The destination and strobe for a request presented before a rising edge are therefore readable just after that edge, and the hotspot count seen by the next request changes on the same edge. The bench drives each request on a falling edge and samples the outputs on the next falling edge. That is one full cycle later, after exactly one register. It advances its own hotspot count at the same point. For cycles without a request, the bench checks that the strobe is low and that the outputs still hold the previously expected destination.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

    typedef enum logic [2:0] {
        PAT_UNIFORM   = 3'd0,
        PAT_COMPL     = 3'd1,
        PAT_REVERSE   = 3'd2,
        PAT_TRANSPOSE = 3'd3,
        PAT_SHUFFLE   = 3'd4,
        PAT_ROTATE    = 3'd5,
        PAT_HOTSPOT   = 3'd6,
        PAT_SPARE     = 3'd7
    } pattern_e;

endpackage

// File: rtl/sdg_permute.sv
// Fixed-permutation destination: complement, reversal, transpose, shuffle, rotation.
module sdg_permute
    import sdg_pkg::*;
#(
    parameter int MESH_X = 5,
    parameter int MESH_Y = 5,
    parameter int XW     = 3,
    parameter int YW     = 3
) (
    input  pattern_e          pat_i,
    input  logic [XW-1:0]     src_x_i,
    input  logic [YW-1:0]     src_y_i,
    output logic [XW-1:0]     dst_x_o,
    output logic [YW-1:0]     dst_y_o
);

    localparam int W     = XW + YW;
    localparam int MAX_X = MESH_X - 1;
    localparam int MAX_Y = MESH_Y - 1;

    logic [W-1:0] cat;
    logic [W-1:0] rev;
    logic [W-1:0] rotl;
    logic [W-1:0] rotr;
    logic [W-1:0] raw_x;
    logic [W-1:0] raw_y;

    assign cat  = {src_y_i, src_x_i};
    assign rotl = {cat[W-2:0], cat[W-1]};
    assign rotr = {cat[0], cat[W-1:1]};

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev[i] = cat[W-1-i];
    end

    always_comb begin
        case (pat_i)
            PAT_REVERSE: begin
                raw_x = W'(rev[XW-1:0]);
                raw_y = W'(rev[W-1:XW]);
            end
            PAT_TRANSPOSE: begin
                raw_x = W'(src_y_i);
                raw_y = W'(src_x_i);
            end
            PAT_SHUFFLE: begin
                raw_x = W'(rotl[XW-1:0]);
                raw_y = W'(rotl[W-1:XW]);
            end
            PAT_ROTATE: begin
                raw_x = W'(rotr[XW-1:0]);
                raw_y = W'(rotr[W-1:XW]);
            end
            default: begin
                raw_x = W'(MAX_X) - W'(src_x_i);
                raw_y = W'(MAX_Y) - W'(src_y_i);
            end
        endcase
    end

    assign dst_x_o = (raw_x > W'(MAX_X)) ? XW'(MAX_X) : raw_x[XW-1:0];
    assign dst_y_o = (raw_y > W'(MAX_Y)) ? YW'(MAX_Y) : raw_y[YW-1:0];

endmodule

// File: rtl/sdg_uniform.sv
// Uniform destination from a random word, stepping past the source node.
module sdg_uniform #(
    parameter int MESH_X = 5,
    parameter int MESH_Y = 5,
    parameter int XW     = 3,
    parameter int YW     = 3,
    parameter int RW     = 16
) (
    input  logic [RW-1:0] rand_i,
    input  logic [XW-1:0] src_x_i,
    input  logic [YW-1:0] src_y_i,
    output logic [XW-1:0] dst_x_o,
    output logic [YW-1:0] dst_y_o
);

    localparam int NODES = MESH_X * MESH_Y;

    int pick;
    int self_idx;

    always_comb begin
        pick     = int'(rand_i) % NODES;
        self_idx = int'(src_y_i) * MESH_X + int'(src_x_i);
        if (pick == self_idx) begin
            pick = (pick + 1) % NODES;
        end
        dst_x_o = XW'(pick % MESH_X);
        dst_y_o = YW'(pick / MESH_X);
    end

endmodule

// File: rtl/synth_dest_gen.sv
// Synthetic traffic destination generator, registered output.
module synth_dest_gen
    import sdg_pkg::*;
#(
    parameter int MESH_X = 5,
    parameter int MESH_Y = 5,
    parameter int CW     = 16,
    parameter int RW     = 16,
    localparam int XW    = (MESH_X > 1) ? $clog2(MESH_X) : 1,
    localparam int YW    = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          req_i,
    input  logic [2:0]    pattern_i,
    input  logic [2:0]    bg_pattern_i,
    input  logic [XW-1:0] src_x_i,
    input  logic [YW-1:0] src_y_i,
    input  logic [XW-1:0] hot_x_i,
    input  logic [YW-1:0] hot_y_i,
    input  logic [CW-1:0] hot_quota_i,
    input  logic [RW-1:0] rand_i,
    output logic [XW-1:0] dst_x_o,
    output logic [YW-1:0] dst_y_o,
    output logic          valid_o
);

    localparam int MAX_X = MESH_X - 1;
    localparam int MAX_Y = MESH_Y - 1;

    typedef struct packed {
        logic          valid;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        logic [CW-1:0] hot_cnt;
    } state_t;

    state_t   st_d;
    state_t   st_q;

    pattern_e pat_req;
    pattern_e pat_bg;
    pattern_e pat_eff;
    logic [CW-1:0] cnt_eff;
    logic          hot_phase;
    logic [XW-1:0] hot_x_c;
    logic [YW-1:0] hot_y_c;
    logic [XW-1:0] perm_x;
    logic [YW-1:0] perm_y;
    logic [XW-1:0] uni_x;
    logic [YW-1:0] uni_y;

    sdg_permute #(
        .MESH_X (MESH_X),
        .MESH_Y (MESH_Y),
        .XW     (XW),
        .YW     (YW)
    ) perm_i (
        .pat_i   (pat_eff),
        .src_x_i (src_x_i),
        .src_y_i (src_y_i),
        .dst_x_o (perm_x),
        .dst_y_o (perm_y)
    );

    sdg_uniform #(
        .MESH_X (MESH_X),
        .MESH_Y (MESH_Y),
        .XW     (XW),
        .YW     (YW),
        .RW     (RW)
    ) uni_i (
        .rand_i  (rand_i),
        .src_x_i (src_x_i),
        .src_y_i (src_y_i),
        .dst_x_o (uni_x),
        .dst_y_o (uni_y)
    );

    always_comb begin
        pat_req = pattern_e'(pattern_i);
        pat_bg  = pattern_e'(bg_pattern_i);
        if (pat_bg == PAT_HOTSPOT || pat_bg == PAT_SPARE) begin
            pat_bg = PAT_COMPL;
        end

        cnt_eff   = start_i ? '0 : st_q.hot_cnt;
        hot_phase = (pat_req == PAT_HOTSPOT) && (cnt_eff < hot_quota_i);

        if (pat_req == PAT_HOTSPOT) begin
            pat_eff = pat_bg;
        end else if (pat_req == PAT_SPARE) begin
            pat_eff = PAT_COMPL;
        end else begin
            pat_eff = pat_req;
        end

        hot_x_c = (int'(hot_x_i) > MAX_X) ? XW'(MAX_X) : hot_x_i;
        hot_y_c = (int'(hot_y_i) > MAX_Y) ? YW'(MAX_Y) : hot_y_i;

        st_d         = st_q;
        st_d.valid   = req_i;
        st_d.hot_cnt = cnt_eff;
        if (req_i) begin
            if (hot_phase) begin
                st_d.x       = hot_x_c;
                st_d.y       = hot_y_c;
                st_d.hot_cnt = cnt_eff + CW'(1);
            end else if (pat_eff == PAT_UNIFORM) begin
                st_d.x = uni_x;
                st_d.y = uni_y;
            end else begin
                st_d.x = perm_x;
                st_d.y = perm_y;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dst_x_o = st_q.x;
    assign dst_y_o = st_q.y;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/sdg_checker.sv
module sdg_checker #(
    parameter int MESH_X = 5,
    parameter int MESH_Y = 5,
    parameter int XW     = 3,
    parameter int YW     = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_i,
    input logic [2:0]    pattern_i,
    input logic [XW-1:0] src_x_i,
    input logic [YW-1:0] src_y_i,
    input logic [XW-1:0] dst_x_o,
    input logic [YW-1:0] dst_y_o,
    input logic          valid_o
);

    localparam int MAX_X = MESH_X - 1;
    localparam int MAX_Y = MESH_Y - 1;

    assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);

    assert_in_mesh_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (int'(dst_x_o) <= MAX_X) && (int'(dst_y_o) <= MAX_Y));

    assert_uniform_not_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && pattern_i == 3'd0 |=> !(dst_x_o == $past(src_x_i) && dst_y_o == $past(src_y_i)));

    assert_complement_x_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && pattern_i == 3'd1 && int'(src_x_i) <= MAX_X
        |=> int'(dst_x_o) == MAX_X - int'($past(src_x_i)));

    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(dst_x_o) && $stable(dst_y_o));

endmodule

bind synth_dest_gen sdg_checker #(
    .MESH_X (MESH_X),
    .MESH_Y (MESH_Y),
    .XW     (XW),
    .YW     (YW)
) chk_i (.*);

// File: tb/synth_dest_gen_tb_top.sv
module synth_dest_gen_tb_top;

    localparam int MX    = 5;
    localparam int MY    = 5;
    localparam int XW    = $clog2(MX);
    localparam int YW    = $clog2(MY);
    localparam int CW    = 16;
    localparam int RW    = 16;
    localparam int NODES = MX * MY;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          req_i = 1'b0;
    logic [2:0]    pattern_i = '0;
    logic [2:0]    bg_pattern_i = '0;
    logic [XW-1:0] src_x_i = '0;
    logic [YW-1:0] src_y_i = '0;
    logic [XW-1:0] hot_x_i = '0;
    logic [YW-1:0] hot_y_i = '0;
    logic [CW-1:0] hot_quota_i = '0;
    logic [RW-1:0] rand_i = '0;
    logic [XW-1:0] dst_x_o;
    logic [YW-1:0] dst_y_o;
    logic          valid_o;

    int checks = 0;
    int errors = 0;
    int mcnt   = 0;
    int exp_x  = 0;
    int exp_y  = 0;

    always #4 clk = ~clk;

    synth_dest_gen #(.MESH_X(MX), .MESH_Y(MY), .CW(CW), .RW(RW)) dut_i (
        .clk, .rst_n, .start_i, .req_i, .pattern_i, .bg_pattern_i,
        .src_x_i, .src_y_i, .hot_x_i, .hot_y_i, .hot_quota_i, .rand_i,
        .dst_x_o, .dst_y_o, .valid_o
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int clampv(int v, int mx);
        return (v > mx) ? mx : v;
    endfunction

    // Reference for the fixed patterns (codes 1..5, others as 1); returns y*256+x.
    function automatic int ref_perm(int p, int sx, int sy);
        int v = sy * (1 << XW) + sx;
        int w = XW + YW;
        int r = 0;
        int rx;
        int ry;
        case (p)
            2: begin
                for (int i = 0; i < w; i++) if (v & (1 << i)) r |= 1 << (w - 1 - i);
                rx = r % (1 << XW); ry = r / (1 << XW);
            end
            3: begin rx = sy; ry = sx; end
            4: begin
                r = ((v << 1) | (v >> (w - 1))) & ((1 << w) - 1);
                rx = r % (1 << XW); ry = r / (1 << XW);
            end
            5: begin
                r = (v >> 1) | ((v & 1) << (w - 1));
                rx = r % (1 << XW); ry = r / (1 << XW);
            end
            default: begin rx = (MX - 1) - sx; ry = (MY - 1) - sy; end
        endcase
        return clampv(ry, MY - 1) * 256 + clampv(rx, MX - 1);
    endfunction

    function automatic int ref_uni(int rv, int sx, int sy);
        int k = rv % NODES;
        if (k == sy * MX + sx) k = (k + 1) % NODES;
        return (k / MX) * 256 + (k % MX);
    endfunction

    // One cycle: drive at negedge, model, sample at the following negedge.
    task automatic step(string tag, bit st, bit rq, int p, int bg, int sx, int sy,
                        int hx, int hy, int q, int rv);
        int eff;
        int bgp;
        int res;
        bit hot;
        start_i = st; req_i = rq; pattern_i = 3'(p); bg_pattern_i = 3'(bg);
        src_x_i = XW'(sx); src_y_i = YW'(sy); hot_x_i = XW'(hx); hot_y_i = YW'(hy);
        hot_quota_i = CW'(q); rand_i = RW'(rv);
        eff = st ? 0 : mcnt;
        hot = (p == 6) && (eff < q);
        mcnt = eff;
        if (rq) begin
            bgp = (bg >= 6) ? 1 : bg;
            if (hot) begin
                res = clampv(hy, MY - 1) * 256 + clampv(hx, MX - 1);
                mcnt = eff + 1;
            end else if (p == 6) begin
                res = (bgp == 0) ? ref_uni(rv, sx, sy) : ref_perm(bgp, sx, sy);
            end else if (p == 0) begin
                res = ref_uni(rv, sx, sy);
            end else begin
                res = ref_perm(p, sx, sy);
            end
            exp_x = res % 256;
            exp_y = res / 256;
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R2 valid"}, int'(valid_o), int'(rq));
        chk({tag, " x"}, int'(dst_x_o), exp_x);
        chk({tag, " y"}, int'(dst_y_o), exp_y);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(valid_o), 0);
        chk("R1 reset x", int'(dst_x_o), 0);
        chk("R1 reset y", int'(dst_y_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset valid", int'(valid_o), 0);

        step("R3 compl 0,0", 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        chk("R3 corner x", int'(dst_x_o), 4);
        step("R3 compl 4,4", 0, 1, 1, 0, 4, 4, 0, 0, 0, 0);
        chk("R3 corner y", int'(dst_y_o), 0);
        step("R4 reverse 1,0", 0, 1, 2, 0, 1, 0, 0, 0, 0, 0);
        chk("R4 reverse y", int'(dst_y_o), 4);
        step("R4 reverse 4,4", 0, 1, 2, 0, 4, 4, 0, 0, 0, 0);
        step("R5 transpose 3,1", 0, 1, 3, 0, 3, 1, 0, 0, 0, 0);
        chk("R5 transpose x", int'(dst_x_o), 1);
        step("R6 shuffle 4,2 clamp", 0, 1, 4, 0, 4, 2, 0, 0, 0, 0);
        chk("R6 shuffle clamp y", int'(dst_y_o), 4);
        step("R7 rotate 1,1", 0, 1, 5, 0, 1, 1, 0, 0, 0, 0);
        step("R8 uniform self skip", 0, 1, 0, 0, 2, 1, 0, 0, 0, 7);
        chk("R8 self skip x", int'(dst_x_o), 3);
        step("R8 uniform wrap", 0, 1, 0, 0, 4, 4, 0, 0, 0, 24 + NODES * 3);
        chk("R8 wrap x", int'(dst_x_o), 0);
        step("R12 spare code", 0, 1, 7, 0, 1, 3, 0, 0, 0, 0);
        step("R12 idle hold", 0, 0, 2, 0, 0, 0, 0, 0, 0, 0);
        step("R11 start", 1, 0, 6, 1, 0, 0, 2, 3, 2, 0);
        step("R9 hot 1", 0, 1, 6, 1, 0, 0, 2, 3, 2, 0);
        chk("R9 hotspot x", int'(dst_x_o), 2);
        step("R9 hot 2", 0, 1, 6, 1, 1, 0, 7, 7, 2, 0);
        chk("R9 hotspot clamp x", int'(dst_x_o), 4);
        step("R10 background", 0, 1, 6, 3, 3, 1, 2, 3, 2, 0);
        chk("R10 background x", int'(dst_x_o), 1);
        step("R10 bg code 6", 0, 1, 6, 6, 0, 1, 2, 3, 2, 0);
        step("R11 start with req", 1, 1, 6, 1, 0, 0, 2, 2, 1, 0);
        chk("R11 restart x", int'(dst_x_o), 2);
        step("R10 quota 0", 1, 1, 6, 0, 2, 2, 1, 1, 0, 12);

        for (int n = 0; n < 3000; n++) begin
            step("R9 R10 random", ($urandom % 16) == 0, ($urandom % 4) != 0,
                 int'($urandom % 8), int'($urandom % 8),
                 int'($urandom % MX), int'($urandom % MY),
                 int'($urandom % 8), int'($urandom % 8),
                 int'($urandom % 6), int'($urandom % 65536));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule